// File: doc/BRIEF.md
# Fewest-in-Flight Fetch Thread Arbiter

This block sits at the front of a simultaneous multithreading fetch unit and decides, every cycle, which hardware thread may fetch. Each thread owns a private instruction buffer queue. For each thread the block tracks how many instructions are in flight: fetched but not yet taken out of the front end. Fetch goes to the ready thread with the lowest count. A thread that floods the front end therefore falls back in priority, and the shared queues stay evenly mixed.

Each cycle the surrounding logic reports, per thread, how many instructions were written into its buffer and how many decode removed. The arbiter updates its counters from these reports and saturates them at the buffer depth. When several ready threads share the lowest count, the tie goes round-robin, starting with the thread after the one granted most recently. The one-hot grant feeds the write enables of the per-thread buffers. A per-thread flush clears that thread's count in one cycle and removes the thread from the current selection.

Top module: `icnt_fetch_arb`

## Requirements
- R1: After reset, every in-flight count reads 0, no grant is raised, and the round-robin pointer is set so that thread 0 wins the first tie.
- R2: A thread can be granted only if its fetch-valid is high, its buffer-full is low and its flush is low. The grant is one-hot or zero. It is zero exactly when no thread qualifies. `grant_valid_o` equals the OR of the grant bits, and `grant_id_o` gives the binary index of the granted thread.
- R3: Among the threads that qualify, the granted thread has the smallest in-flight count.
- R4: When several qualifying threads share the smallest count, the winner is the first of them in round-robin order, starting one thread after the most recently granted thread.
- R5: In each cycle without flush, a thread's count becomes count + entering − leaving. Both changes take effect in the same cycle, and each is 0 to 4 instructions.
- R6: The count saturates at the buffer depth `BUF_DEPTH` (8 in the bench) and never drops below 0.
- R7: Flush forces the thread's count to 0 on the next cycle, regardless of entering or leaving traffic in that cycle.
- R8: In a cycle with no grant, the round-robin pointer keeps its value.
- R9: Per-thread buses are packed with thread i in bits [i*W +: W]. This applies to the entering and leaving counts (W = 3) and to the count outputs (W = $clog2(BUF_DEPTH+1)).

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous active-low reset |
| fetch_valid_i | input | NUM_THREADS | Thread has a fetch address ready |
| buf_full_i | input | NUM_THREADS | Thread's instruction buffer cannot accept a fetch |
| flush_i | input | NUM_THREADS | Clear thread's in-flight count |
| enter_num_i | input | NUM_THREADS*3 | Instructions written into each thread's buffer this cycle |
| leave_num_i | input | NUM_THREADS*3 | Instructions decode removed from each thread's buffer this cycle |
| fetch_grant_o | output | NUM_THREADS | One-hot fetch grant, drives buffer write enables |
| grant_valid_o | output | 1 | Some thread is granted |
| grant_id_o | output | $clog2(NUM_THREADS) | Index of granted thread |
| inflight_o | output | NUM_THREADS*$clog2(BUF_DEPTH+1) | Per-thread in-flight counts |

## Verification
The bench targets ties among equal counts. A design that restarted its search at thread 0 would starve the upper threads. A design that moved its pointer on idle cycles would skip a thread. The bench also drives entries past the buffer depth and removals past zero, where a counter without clamping would wrap to a small value or a huge one and then win or lose arbitration wrongly. Full buffers and flush are checked together with arrivals in the same cycle: a flushed thread that is still counted, or a full thread that is still granted, both show up directly at the grant or count outputs.

// File: rtl/icnt_pkg.sv
package icnt_pkg;

    localparam int MAX_THREADS = 4;
    localparam int MIN_THREADS = 2;
    localparam int MAX_FETCH   = 4;

    // Saturating update: add arrivals, remove departures, clamp to [0, limit].
    function automatic int unsigned icnt_next(
        input int unsigned cur,
        input int unsigned add,
        input int unsigned sub,
        input int unsigned limit
    );
        int unsigned sum;
        sum = cur + add;
        if (sub >= sum) begin
            return 0;
        end
        sum = sum - sub;
        if (sum > limit) begin
            return limit;
        end
        return sum;
    endfunction

endpackage

// File: rtl/icnt_thread_ctr.sv
module icnt_thread_ctr
    import icnt_pkg::*;
#(
    parameter int BUF_DEPTH = 16,
    parameter int NUM_W     = 3,
    parameter int CNT_W     = $clog2(BUF_DEPTH + 1)
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             fetch_valid,
    input  logic             buf_full,
    input  logic             flush,
    input  logic [NUM_W-1:0] enter_num,
    input  logic [NUM_W-1:0] leave_num,
    output logic             eligible,
    output logic [CNT_W-1:0] count
);

    typedef struct packed {
        logic [CNT_W-1:0] cnt;
    } ctr_state_t;

    ctr_state_t st_d, st_q;

    always_comb begin
        st_d = st_q;
        if (flush) begin
            st_d.cnt = '0;
        end else begin
            st_d.cnt = CNT_W'(icnt_next(int'(st_q.cnt), int'(enter_num),
                                        int'(leave_num), BUF_DEPTH));
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            st_q <= '0;
        end else begin
            st_q <= st_d;
        end
    end

    assign eligible = fetch_valid & ~buf_full & ~flush;
    assign count    = st_q.cnt;

endmodule

// File: rtl/icnt_min_select.sv
module icnt_min_select #(
    parameter int NUM_THREADS = 4,
    parameter int CNT_W       = 5,
    parameter int TID_W       = $clog2(NUM_THREADS)
) (
    input  logic [NUM_THREADS-1:0]       eligible,
    input  logic [NUM_THREADS*CNT_W-1:0] counts,
    input  logic [TID_W-1:0]             last_id,
    output logic [NUM_THREADS-1:0]       grant,
    output logic [TID_W-1:0]             grant_id,
    output logic                         grant_valid
);

    // Walk threads in round-robin order starting after last_id; a strictly
    // smaller count replaces the current pick, so equal counts keep the
    // earliest thread in that order.
    always_comb begin
        logic [CNT_W-1:0] best_cnt;
        logic             found;
        int               pick;
        int               idx;
        best_cnt = '0;
        found    = 1'b0;
        pick     = 0;
        for (int k = 1; k <= NUM_THREADS; k++) begin
            idx = (int'(last_id) + k) % NUM_THREADS;
            if (eligible[idx]) begin
                if (!found || (counts[idx*CNT_W +: CNT_W] < best_cnt)) begin
                    found    = 1'b1;
                    pick     = idx;
                    best_cnt = counts[idx*CNT_W +: CNT_W];
                end
            end
        end
        grant       = '0;
        grant_id    = '0;
        grant_valid = found;
        if (found) begin
            grant[pick] = 1'b1;
            grant_id    = TID_W'(pick);
        end
    end

endmodule

// File: rtl/icnt_fetch_arb.sv
module icnt_fetch_arb
    import icnt_pkg::*;
#(
    parameter int NUM_THREADS = 4,
    parameter int FETCH_W     = 4,
    parameter int BUF_DEPTH   = 16,
    parameter int NUM_W       = $clog2(FETCH_W + 1),
    parameter int CNT_W       = $clog2(BUF_DEPTH + 1),
    parameter int TID_W       = $clog2(NUM_THREADS)
) (
    input  logic                         clk,
    input  logic                         rst_n,
    input  logic [NUM_THREADS-1:0]       fetch_valid_i,
    input  logic [NUM_THREADS-1:0]       buf_full_i,
    input  logic [NUM_THREADS-1:0]       flush_i,
    input  logic [NUM_THREADS*NUM_W-1:0] enter_num_i,
    input  logic [NUM_THREADS*NUM_W-1:0] leave_num_i,
    output logic [NUM_THREADS-1:0]       fetch_grant_o,
    output logic                         grant_valid_o,
    output logic [TID_W-1:0]             grant_id_o,
    output logic [NUM_THREADS*CNT_W-1:0] inflight_o
);

    if (NUM_THREADS < MIN_THREADS || NUM_THREADS > MAX_THREADS) begin : g_bad_threads
        $error("icnt_fetch_arb: NUM_THREADS out of range");
    end
    if (FETCH_W < 1 || FETCH_W > MAX_FETCH) begin : g_bad_fetch
        $error("icnt_fetch_arb: FETCH_W out of range");
    end

    logic [NUM_THREADS-1:0] elig;
    logic [NUM_THREADS-1:0] grant;
    logic [TID_W-1:0]       gid;
    logic                   gvalid;

    for (genvar t = 0; t < NUM_THREADS; t++) begin : g_thr
        icnt_thread_ctr #(
            .BUF_DEPTH (BUF_DEPTH),
            .NUM_W     (NUM_W),
            .CNT_W     (CNT_W)
        ) u_ctr (
            .clk         (clk),
            .rst_n       (rst_n),
            .fetch_valid (fetch_valid_i[t]),
            .buf_full    (buf_full_i[t]),
            .flush       (flush_i[t]),
            .enter_num   (enter_num_i[t*NUM_W +: NUM_W]),
            .leave_num   (leave_num_i[t*NUM_W +: NUM_W]),
            .eligible    (elig[t]),
            .count       (inflight_o[t*CNT_W +: CNT_W])
        );
    end

    typedef struct packed {
        logic [TID_W-1:0] last;
    } rr_state_t;

    rr_state_t rr_d, rr_q;

    icnt_min_select #(
        .NUM_THREADS (NUM_THREADS),
        .CNT_W       (CNT_W),
        .TID_W       (TID_W)
    ) u_sel (
        .eligible    (elig),
        .counts      (inflight_o),
        .last_id     (rr_q.last),
        .grant       (grant),
        .grant_id    (gid),
        .grant_valid (gvalid)
    );

    always_comb begin
        rr_d = rr_q;
        if (gvalid) begin
            rr_d.last = gid;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            rr_q.last <= TID_W'(NUM_THREADS - 1);
        end else begin
            rr_q <= rr_d;
        end
    end

    assign fetch_grant_o = grant;
    assign grant_valid_o = gvalid;
    assign grant_id_o    = gid;

endmodule

// File: rtl/icnt_fetch_arb_chk.sv
module icnt_fetch_arb_chk #(
    parameter int NUM_THREADS = 4,
    parameter int BUF_DEPTH   = 16,
    parameter int NUM_W       = 3,
    parameter int CNT_W       = 5,
    parameter int TID_W       = 2
) (
    input logic                         clk,
    input logic                         rst_n,
    input logic [NUM_THREADS-1:0]       fetch_valid_i,
    input logic [NUM_THREADS-1:0]       buf_full_i,
    input logic [NUM_THREADS-1:0]       flush_i,
    input logic [NUM_THREADS*NUM_W-1:0] enter_num_i,
    input logic [NUM_THREADS*NUM_W-1:0] leave_num_i,
    input logic [NUM_THREADS-1:0]       fetch_grant_o,
    input logic                         grant_valid_o,
    input logic [TID_W-1:0]             grant_id_o,
    input logic [NUM_THREADS*CNT_W-1:0] inflight_o
);

    logic [NUM_THREADS-1:0] ready;
    assign ready = fetch_valid_i & ~buf_full_i & ~flush_i;

    AST_GRANT_ONEHOT: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0(fetch_grant_o)); // R2

    AST_GRANT_READY: assert property (@(posedge clk) disable iff (!rst_n)
        (fetch_grant_o & ~ready) == '0); // R2

    AST_GRANT_IF_ANY: assert property (@(posedge clk) disable iff (!rst_n)
        (ready != '0) |-> grant_valid_o); // R2

    AST_VALID_MATCH: assert property (@(posedge clk) disable iff (!rst_n)
        grant_valid_o == (fetch_grant_o != '0)); // R2

    for (genvar i = 0; i < NUM_THREADS; i++) begin : g_i
        AST_ID_MATCH: assert property (@(posedge clk) disable iff (!rst_n)
            fetch_grant_o[i] |-> (int'(grant_id_o) == i)); // R2

        AST_CNT_LIMIT: assert property (@(posedge clk) disable iff (!rst_n)
            int'(inflight_o[i*CNT_W +: CNT_W]) <= BUF_DEPTH); // R6

        AST_FLUSH_CLEAR: assert property (@(posedge clk) disable iff (!rst_n)
            flush_i[i] |=> (inflight_o[i*CNT_W +: CNT_W] == '0)); // R7

        AST_CNT_STEP: assert property (@(posedge clk) disable iff (!rst_n)
            (!flush_i[i]
             && (int'(inflight_o[i*CNT_W +: CNT_W]) + int'(enter_num_i[i*NUM_W +: NUM_W])
                 >= int'(leave_num_i[i*NUM_W +: NUM_W]))
             && (int'(inflight_o[i*CNT_W +: CNT_W]) + int'(enter_num_i[i*NUM_W +: NUM_W])
                 - int'(leave_num_i[i*NUM_W +: NUM_W]) <= BUF_DEPTH))
            |=> (int'(inflight_o[i*CNT_W +: CNT_W]) ==
                 $past(int'(inflight_o[i*CNT_W +: CNT_W]) + int'(enter_num_i[i*NUM_W +: NUM_W])
                       - int'(leave_num_i[i*NUM_W +: NUM_W])))); // R5

        for (genvar j = 0; j < NUM_THREADS; j++) begin : g_j
            AST_GRANT_MIN: assert property (@(posedge clk) disable iff (!rst_n)
                (fetch_grant_o[i] && ready[j]) |->
                (inflight_o[i*CNT_W +: CNT_W] <= inflight_o[j*CNT_W +: CNT_W])); // R3
        end
    end

endmodule

bind icnt_fetch_arb icnt_fetch_arb_chk #(
    .NUM_THREADS (NUM_THREADS),
    .BUF_DEPTH   (BUF_DEPTH),
    .NUM_W       (NUM_W),
    .CNT_W       (CNT_W),
    .TID_W       (TID_W)
) u_chk (
    .clk           (clk),
    .rst_n         (rst_n),
    .fetch_valid_i (fetch_valid_i),
    .buf_full_i    (buf_full_i),
    .flush_i       (flush_i),
    .enter_num_i   (enter_num_i),
    .leave_num_i   (leave_num_i),
    .fetch_grant_o (fetch_grant_o),
    .grant_valid_o (grant_valid_o),
    .grant_id_o    (grant_id_o),
    .inflight_o    (inflight_o)
);

// File: tb/tb_icnt_fetch_arb.sv
module tb_icnt_fetch_arb;

    localparam int T     = 4;
    localparam int DEPTH = 8;
    localparam int NW    = 3;
    localparam int CW    = 4;
    localparam int TW    = 2;

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic [T-1:0]  valid = '0, full = '0, flush = '0;
    logic [T*NW-1:0] enter = '0, leave = '0;
    logic [T-1:0]  grant;
    logic          gvalid;
    logic [TW-1:0] gid;
    logic [T*CW-1:0] cnts;

    int tests = 0;
    int fails = 0;
    int m_cnt [T];
    int m_last;

    always #5 clk = ~clk;

    icnt_fetch_arb #(.NUM_THREADS(T), .FETCH_W(4), .BUF_DEPTH(DEPTH)) dut (
        .clk (clk), .rst_n (rst_n),
        .fetch_valid_i (valid), .buf_full_i (full), .flush_i (flush),
        .enter_num_i (enter), .leave_num_i (leave),
        .fetch_grant_o (grant), .grant_valid_o (gvalid),
        .grant_id_o (gid), .inflight_o (cnts)
    );

    // vector: {valid[4], full[4], flush[4], enter t3..t0, leave t3..t0}
    localparam logic [35:0] VEC [12] = '{
        {4'b1111, 4'b0000, 4'b0000, {3'd0,3'd0,3'd0,3'd2}, {3'd0,3'd0,3'd0,3'd0}},
        {4'b1111, 4'b0000, 4'b0000, {3'd0,3'd0,3'd3,3'd0}, {3'd0,3'd0,3'd0,3'd0}},
        {4'b1111, 4'b0000, 4'b0000, {3'd0,3'd1,3'd0,3'd0}, {3'd0,3'd0,3'd0,3'd0}},
        {4'b1111, 4'b0000, 4'b0000, {3'd2,3'd0,3'd0,3'd0}, {3'd0,3'd0,3'd0,3'd1}},
        {4'b1111, 4'b0001, 4'b0000, {3'd0,3'd0,3'd0,3'd0}, {3'd0,3'd0,3'd1,3'd0}},
        {4'b0110, 4'b0000, 4'b0000, {3'd0,3'd0,3'd1,3'd0}, {3'd0,3'd0,3'd0,3'd0}},
        {4'b1111, 4'b0000, 4'b0100, {3'd4,3'd4,3'd4,3'd4}, {3'd0,3'd0,3'd0,3'd0}},
        {4'b1111, 4'b0000, 4'b0000, {3'd4,3'd4,3'd4,3'd4}, {3'd1,3'd2,3'd3,3'd4}},
        {4'b1111, 4'b1000, 4'b0000, {3'd4,3'd0,3'd4,3'd0}, {3'd0,3'd4,3'd0,3'd4}},
        {4'b1011, 4'b0000, 4'b0000, {3'd0,3'd0,3'd0,3'd0}, {3'd4,3'd4,3'd4,3'd4}},
        {4'b0000, 4'b0000, 4'b1111, {3'd1,3'd1,3'd1,3'd1}, {3'd0,3'd0,3'd0,3'd0}},
        {4'b1111, 4'b0000, 4'b0000, {3'd0,3'd0,3'd0,3'd0}, {3'd0,3'd0,3'd0,3'd0}}
    };

    task automatic chk(input string req, input int act, input int exp);
        tests++;
        if (act != exp) begin
            fails++;
            $display("FAIL %s: actual %0d expected %0d", req, act, exp);
        end
    endtask

    // Reference pick from the requirements: lowest count, ties in
    // round-robin order after the last granted thread.
    function automatic int model_pick(input logic [35:0] v);
        int pick = -1;
        for (int k = 1; k <= T; k++) begin
            int idx = (m_last + k) % T;
            if (v[32+idx] && !v[28+idx] && !v[24+idx]) begin
                if (pick < 0 || m_cnt[idx] < m_cnt[pick]) pick = idx;
            end
        end
        return pick;
    endfunction

    // exp_hand >= -1 is a hand-derived grant; -2 means use the model.
    task automatic step(input logic [35:0] v, input int exp_hand, input string req);
        int exp_g;
        @(negedge clk);
        valid = v[35:32]; full = v[31:28]; flush = v[27:24];
        enter = v[23:12]; leave = v[11:0];
        #2;
        exp_g = model_pick(v);
        if (exp_hand >= -1) chk({req, " hand grant"}, exp_g, exp_hand);
        chk({req, " grant"}, int'(grant), (exp_g < 0) ? 0 : (1 << exp_g));
        chk("R2 grant_valid", int'(gvalid), (exp_g < 0) ? 0 : 1);
        if (exp_g >= 0) chk("R2 grant_id", int'(gid), exp_g);
        @(posedge clk);
        #1;
        valid = '0; full = '0; flush = '0; enter = '0; leave = '0;
        if (exp_g >= 0) m_last = exp_g;
        for (int t = 0; t < T; t++) begin
            int s;
            if (v[24+t]) m_cnt[t] = 0;
            else begin
                s = m_cnt[t] + int'(v[12+NW*t +: NW]) - int'(v[NW*t +: NW]);
                m_cnt[t] = (s < 0) ? 0 : ((s > DEPTH) ? DEPTH : s);
            end
        end
        for (int t = 0; t < T; t++)
            chk("R5/R6/R7/R9 count", int'(cnts[t*CW +: CW]), m_cnt[t]);
    endtask

    task automatic do_reset();
        rst_n = 1'b0;
        for (int t = 0; t < T; t++) m_cnt[t] = 0;
        m_last = T - 1;
        repeat (2) @(negedge clk);
        for (int t = 0; t < T; t++) chk("R1 reset count", int'(cnts[t*CW +: CW]), 0);
        chk("R1 reset grant", int'(grant), 0);
        rst_n = 1'b1;
    endtask

    function automatic logic [35:0] mk(input logic [3:0] va, input logic [3:0] fu,
                                       input logic [3:0] fl, input logic [11:0] en,
                                       input logic [11:0] lv);
        return {va, fu, fl, en, lv};
    endfunction

    initial begin
        #(200000 * 10);
        fails++;
        $display("FAIL watchdog: actual hung expected done");
        $display("[TB] %0d tests run, %0d failed", tests, fails);
        $finish;
    end

    initial begin
        do_reset();
        foreach (VEC[i]) step(VEC[i], -2, "R3/R4 table");

        // directed corner cases
        do_reset();
        step(mk(4'b1111, 0, 0, 0, 0), 0, "R1 first tie");
        step(mk(4'b1111, 0, 0, 0, 0), 1, "R4 rotate");
        step(mk(4'b1111, 4'b0100, 0, 0, 0), 3, "R2 full skipped");
        step(mk(4'b0000, 0, 0, 0, 0), -1, "R2 none ready");
        step(mk(4'b1111, 0, 0, {3'd0,3'd0,3'd0,3'd4}, 0), 0, "R8 pointer held");
        step(mk(4'b1111, 0, 0, {3'd0,3'd0,3'd0,3'd4}, 0), 1, "R3 min count");
        step(mk(4'b1111, 0, 0, {3'd0,3'd0,3'd0,3'd4}, 0), 2, "R4 tie after min");
        chk("R6 saturate", int'(cnts[0 +: CW]), 8);
        step(mk(4'b1111, 0, 0, {3'd0,3'd0,3'd0,3'd1}, {3'd0,3'd0,3'd0,3'd4}), 3, "R4 wrap");
        chk("R5 enter and leave", int'(cnts[0 +: CW]), 5);
        step(mk(4'b1111, 0, 0, {3'd0,3'd1,3'd2,3'd0}, {3'd0,3'd0,3'd0,3'd4}), 1, "R3 skip busy");
        step(mk(4'b1111, 0, 0, 0, {3'd0,3'd0,3'd0,3'd4}), 3, "R3 lowest");
        chk("R6 floor", int'(cnts[0 +: CW]), 0);
        step(mk(4'b1111, 0, 4'b0010, {3'd0,3'd0,3'd4,3'd0}, 0), 0, "R2 flushed skipped");
        chk("R7 flush clears", int'(cnts[CW +: CW]), 0);
        step(mk(4'b0100, 0, 0, 0, 0), 2, "R3 single ready");

        $display("[TB] %0d tests run, %0d failed", tests, fails);
        $finish;
    end

endmodule